// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt microsequencer of a small 16-bit processor core. It accepts one of five event sources: a non-maskable request, a single-step request raised after each completed instruction, a maskable request, a software interrupt that carries its own 8-bit type, and a return request. For an interrupt it saves the flag word, the code segment and the instruction pointer on a downward-growing stack in memory. It clears the interrupt-enable and trap flags. It then fetches the handler's segment and offset from a vector table at address zero, which holds four bytes per type. For a return it restores the three words in the reverse order.

The sequencer owns the FLAGS, CS, IP and SP registers and drives one synchronous memory port. The port makes one word access per cycle, and read data arrives in the cycle after the read strobe. Before an event, the execution unit loads the registers through a simple load port. A maskable request is resolved through an acknowledge handshake: the interrupting device answers with a one-cycle valid strobe and places the type number on the low byte of the read-data bus.

Top module: `intseq_top`

## Requirements
- R1: After reset, busy, int_ack, mem_we and mem_re are low, and FLAGS, CS, IP and SP read zero.
- R2: On interrupt entry, the block writes three words with SP pre-decremented by 2 before each write. The pre-entry FLAGS goes to SP0-2, CS to SP0-4 and IP to SP0-6, and SP ends at SP0-6.
- R3: After entry, FLAGS equals its pre-entry value with bit 9 (interrupt enable) and bit 8 (trap) cleared. The stacked copy keeps both bits as they were.
- R4: After entry for type t, CS holds the word read from byte address 4t+2 and IP holds the word read from byte address 4t.
- R5: A return request reads IP from SP, then CS from SP+2, then FLAGS from SP+4, incrementing SP by 2 after each read, so SP ends 6 higher.
- R6: A maskable request is ignored while FLAGS bit 9 is clear: busy stays low and no register changes.
- R7: A non-maskable request is taken with type 2 whatever the flag bits are.
- R8: A single-step request is taken with type 1 only while FLAGS bit 8 is set, and is ignored otherwise.
- R9: When several sources request in the same cycle, the order is non-maskable, then single-step, then maskable, then software, then return.
- R10: For an accepted maskable request, int_ack stays high until ack_valid is seen, and the type is taken from mem_rdata[7:0] in that cycle.
- R11: busy rises in the cycle after a request is accepted. It stays high for exactly 6 cycles for a non-maskable, single-step or software entry (plus the acknowledge wait for a maskable one) and for exactly 4 cycles for a return.
- R12: With busy low, ld_en writes ld_data into FLAGS, CS, IP or SP for ld_sel values 0, 1, 2 and 3 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request |
| step_req | input | 1 | Instruction-completed pulse for single-step |
| mask_req | input | 1 | Maskable request |
| sw_req | input | 1 | Software interrupt request |
| sw_type | input | 8 | Type of the software interrupt |
| ret_req | input | 1 | Interrupt-return request |
| int_ack | output | 1 | Acknowledge to the maskable source |
| ack_valid | input | 1 | Device strobe: type is on mem_rdata[7:0] |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 2 | Register select: 0 FLAGS, 1 CS, 2 IP, 3 SP |
| ld_data | input | 16 | Register load value |
| mem_addr | output | 16 | Byte address of the memory access |
| mem_we | output | 1 | Word write strobe |
| mem_re | output | 1 | Word read strobe, data next cycle |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, or type byte during acknowledge |
| busy | output | 1 | Entry or return in progress |
| flags_o | output | 16 | FLAGS register |
| cs_o | output | 16 | CS register |
| ip_o | output | 16 | IP register |
| sp_o | output | 16 | SP register |

## Verification
The assertions take for granted that read data appears exactly one cycle after mem_re and that ack_valid arrives only while int_ack is high. The bench's memory model and acknowledging device keep to both of these rules. The assertions also assume that the register load port is not used while busy is high. The bench loads registers only between complete sequences and raises a request for a single cycle only. It keeps stacks at byte addresses of 1024 and above, so they can never overlap the vector table.

// File: rtl/intseq_pkg.sv
// Shared types for the interrupt sequencer.
// Assumes: nothing beyond the enumerations below.
package intseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_ACK,
        S_PSH_F, S_PSH_C, S_PSH_I,
        S_VEC_C, S_VEC_I, S_VEC_END,
        S_POP_I, S_POP_C, S_POP_F, S_POP_END
    } seq_st_t;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_NMI, SRC_STEP, SRC_MASK, SRC_SW, SRC_RET
    } src_t;

endpackage

// File: rtl/intseq_arb.sv
// Fixed-priority selection among the event sources.
// Assumes: the requests are sampled only while the sequencer is idle.
module intseq_arb
    import intseq_pkg::*;
#(
    parameter int TYPE_W   = 8,
    parameter int NMI_VEC  = 2,
    parameter int STEP_VEC = 1
) (
    input  logic              nmi_req,
    input  logic              step_req,
    input  logic              trap_on,
    input  logic              mask_req,
    input  logic              ien_on,
    input  logic              sw_req,
    input  logic [TYPE_W-1:0] sw_type,
    input  logic              ret_req,
    output src_t              sel,
    output logic [TYPE_W-1:0] sel_type
);

    // Picks the winning source and its type number.
    always_comb begin
        sel      = SRC_NONE;
        sel_type = '0;
        if (nmi_req) begin
            sel      = SRC_NMI;
            sel_type = TYPE_W'(NMI_VEC);
        end else if (step_req && trap_on) begin
            sel      = SRC_STEP;
            sel_type = TYPE_W'(STEP_VEC);
        end else if (mask_req && ien_on) begin
            sel      = SRC_MASK;
        end else if (sw_req) begin
            sel      = SRC_SW;
            sel_type = sw_type;
        end else if (ret_req) begin
            sel      = SRC_RET;
        end
    end

endmodule

// File: rtl/intseq_core.sv
// Sequencer state machine plus the FLAGS, CS, IP and SP registers.
// Drives one word access per cycle; read data is expected one cycle
// after mem_re. Vector entries are four bytes at address type*4.
module intseq_core
    import intseq_pkg::*;
#(
    parameter int W        = 16,
    parameter int TYPE_W   = 8,
    parameter int IF_POS   = 9,
    parameter int TF_POS   = 8,
    parameter int NMI_VEC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  src_t              sel,
    input  logic [TYPE_W-1:0] sel_type,
    output logic              int_ack,
    input  logic              ack_valid,
    input  logic              ld_en,
    input  logic [1:0]        ld_sel,
    input  logic [W-1:0]      ld_data,
    output logic [W-1:0]      mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [W-1:0]      mem_wdata,
    input  logic [W-1:0]      mem_rdata,
    output logic              busy,
    output logic [W-1:0]      flags_q,
    output logic [W-1:0]      cs_q,
    output logic [W-1:0]      ip_q,
    output logic [W-1:0]      sp_q
);

    localparam logic [W-1:0] STEP2 = W'(2);
    localparam int           PAD_W = W - TYPE_W - 2;

    seq_st_t           state;
    logic [TYPE_W-1:0] type_q;
    logic [W-1:0]      vec_base;

    assign vec_base = {{PAD_W{1'b0}}, type_q, 2'b00};
    assign busy     = (state != S_IDLE);
    assign int_ack  = (state == S_ACK);

    // Memory strobes, address and write data for the current step.
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            S_PSH_F: begin mem_we = 1'b1; mem_addr = sp_q - STEP2; mem_wdata = flags_q; end
            S_PSH_C: begin mem_we = 1'b1; mem_addr = sp_q - STEP2; mem_wdata = cs_q;    end
            S_PSH_I: begin mem_we = 1'b1; mem_addr = sp_q - STEP2; mem_wdata = ip_q;    end
            S_VEC_C: begin mem_re = 1'b1; mem_addr = vec_base + STEP2; end
            S_VEC_I: begin mem_re = 1'b1; mem_addr = vec_base;         end
            S_POP_I, S_POP_C, S_POP_F: begin mem_re = 1'b1; mem_addr = sp_q; end
            default: ;
        endcase
    end

    // State sequencing and register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            type_q  <= '0;
            flags_q <= '0;
            cs_q    <= '0;
            ip_q    <= '0;
            sp_q    <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (sel == SRC_MASK) begin
                        state <= S_ACK;
                    end else if (sel == SRC_RET) begin
                        state <= S_POP_I;
                    end else if (sel != SRC_NONE) begin
                        type_q <= sel_type;
                        state  <= S_PSH_F;
                    end else if (ld_en) begin
                        case (ld_sel)
                            2'd0:    flags_q <= ld_data;
                            2'd1:    cs_q    <= ld_data;
                            2'd2:    ip_q    <= ld_data;
                            default: sp_q    <= ld_data;
                        endcase
                    end
                end
                S_ACK: begin
                    if (ack_valid) begin
                        type_q <= mem_rdata[TYPE_W-1:0];
                        state  <= S_PSH_F;
                    end
                end
                S_PSH_F: begin
                    sp_q            <= sp_q - STEP2;
                    flags_q[IF_POS] <= 1'b0;
                    flags_q[TF_POS] <= 1'b0;
                    state           <= S_PSH_C;
                end
                S_PSH_C: begin
                    sp_q  <= sp_q - STEP2;
                    state <= S_PSH_I;
                end
                S_PSH_I: begin
                    sp_q  <= sp_q - STEP2;
                    state <= S_VEC_C;
                end
                S_VEC_C:   state <= S_VEC_I;
                S_VEC_I: begin
                    cs_q  <= mem_rdata;
                    state <= S_VEC_END;
                end
                S_VEC_END: begin
                    ip_q  <= mem_rdata;
                    state <= S_IDLE;
                end
                S_POP_I: begin
                    sp_q  <= sp_q + STEP2;
                    state <= S_POP_C;
                end
                S_POP_C: begin
                    ip_q  <= mem_rdata;
                    sp_q  <= sp_q + STEP2;
                    state <= S_POP_F;
                end
                S_POP_F: begin
                    cs_q  <= mem_rdata;
                    sp_q  <= sp_q + STEP2;
                    state <= S_POP_END;
                end
                S_POP_END: begin
                    flags_q <= mem_rdata;
                    state   <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2: every write leaves SP equal to the address just written.
    p_push_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_q == $past(mem_addr));

    // R3: both flag bits are already clear while CS is being stacked.
    p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PSH_C) |-> (!flags_q[IF_POS] && !flags_q[TF_POS]));

    // R4: vector reads stay inside the table at the bottom of memory.
    p_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_VEC_C || state == S_VEC_I) |-> (mem_addr >> (TYPE_W + 2)) == '0);

    // R5: each stack read leaves SP two above the address read.
    p_pop_sp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && state inside {S_POP_I, S_POP_C, S_POP_F}) |=> sp_q == $past(mem_addr) + STEP2);

    // R6: a maskable source is only chosen while interrupts are enabled.
    p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && sel == SRC_MASK) |-> flags_q[IF_POS]);

    // R7: a non-maskable acceptance starts pushing with type 2.
    p_nmi_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && sel == SRC_NMI) |=> (state == S_PSH_F && type_q == TYPE_W'(NMI_VEC)));

    // R10: acknowledge holds until the device strobe; one port action per cycle.
    p_ack_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !ack_valid) |=> int_ack);
    p_port_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re, int_ack}));

    // R11: a return ends with busy falling right after the FLAGS load.
    p_ret_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POP_END) |=> !busy);

endmodule

// File: rtl/intseq_top.sv
// Interrupt entry and return sequencer: arbiter plus sequencing core.
// Assumes: one-cycle memory read latency and requests sampled while idle.
module intseq_top
    import intseq_pkg::*;
#(
    parameter int W        = 16,
    parameter int TYPE_W   = 8,
    parameter int IF_POS   = 9,
    parameter int TF_POS   = 8,
    parameter int NMI_VEC  = 2,
    parameter int STEP_VEC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_req,
    input  logic              step_req,
    input  logic              mask_req,
    input  logic              sw_req,
    input  logic [TYPE_W-1:0] sw_type,
    input  logic              ret_req,
    output logic              int_ack,
    input  logic              ack_valid,
    input  logic              ld_en,
    input  logic [1:0]        ld_sel,
    input  logic [W-1:0]      ld_data,
    output logic [W-1:0]      mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [W-1:0]      mem_wdata,
    input  logic [W-1:0]      mem_rdata,
    output logic              busy,
    output logic [W-1:0]      flags_o,
    output logic [W-1:0]      cs_o,
    output logic [W-1:0]      ip_o,
    output logic [W-1:0]      sp_o
);

    src_t              sel;
    logic [TYPE_W-1:0] sel_type;

    intseq_arb #(
        .TYPE_W   (TYPE_W),
        .NMI_VEC  (NMI_VEC),
        .STEP_VEC (STEP_VEC)
    ) u_arb (
        .nmi_req  (nmi_req),
        .step_req (step_req),
        .trap_on  (flags_o[TF_POS]),
        .mask_req (mask_req),
        .ien_on   (flags_o[IF_POS]),
        .sw_req   (sw_req),
        .sw_type  (sw_type),
        .ret_req  (ret_req),
        .sel      (sel),
        .sel_type (sel_type)
    );

    intseq_core #(
        .W       (W),
        .TYPE_W  (TYPE_W),
        .IF_POS  (IF_POS),
        .TF_POS  (TF_POS),
        .NMI_VEC (NMI_VEC)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .sel_type  (sel_type),
        .int_ack   (int_ack),
        .ack_valid (ack_valid),
        .ld_en     (ld_en),
        .ld_sel    (ld_sel),
        .ld_data   (ld_data),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .flags_q   (flags_o),
        .cs_q      (cs_o),
        .ip_q      (ip_o),
        .sp_q      (sp_o)
    );

endmodule

// File: tb/intseq_top_bench.sv
// Bench for the interrupt sequencer: memory model with a computed vector
// table, an acknowledging device, and a sweep over all software types.
module intseq_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 1'b0, step_req = 1'b0, mask_req = 1'b0;
    logic        sw_req = 1'b0, ret_req = 1'b0;
    logic [7:0]  sw_type = '0;
    logic        int_ack;
    logic        ack_valid = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, mem_re, busy;
    logic [15:0] flags_o, cs_o, ip_o, sp_o;

    logic [15:0] stk [0:1023];
    logic [15:0] rd_mem = '0;
    logic        dev_drv = 1'b0;
    logic [7:0]  dev_type = 8'h21;
    logic        ack_seen = 1'b0;
    int          n_chk = 0, n_bad = 0;
    int          wait_cnt = 0;

    always #4 clk = ~clk;

    intseq_top u_intseq_top (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .step_req(step_req),
        .mask_req(mask_req), .sw_req(sw_req), .sw_type(sw_type), .ret_req(ret_req),
        .int_ack(int_ack), .ack_valid(ack_valid), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_data(ld_data), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
        .flags_o(flags_o), .cs_o(cs_o), .ip_o(ip_o), .sp_o(sp_o)
    );

    function automatic logic [15:0] ip_of(input int t);
        return 16'(16'h1000 + t * 6);
    endfunction

    function automatic logic [15:0] cs_of(input int t);
        return 16'(16'h4000 + t * 3);
    endfunction

    function automatic logic [15:0] vec_word(input logic [15:0] a);
        return a[1] ? cs_of(int'(a[9:2])) : ip_of(int'(a[9:2]));
    endfunction

    // Memory: vector table computed below byte 1024, array-backed stack above.
    always @(posedge clk) begin
        if (mem_we) stk[mem_addr[10:1]] <= mem_wdata;
        if (mem_re) rd_mem <= (mem_addr < 16'd1024) ? vec_word(mem_addr) : stk[mem_addr[10:1]];
    end

    assign mem_rdata = dev_drv ? {8'h00, dev_type} : rd_mem;

    // Device: answers an acknowledge after two cycles with a one-cycle strobe.
    initial begin
        forever begin
            @(negedge clk);
            if (ack_valid) begin
                ack_valid = 1'b0;
                dev_drv   = 1'b0;
            end else if (int_ack) begin
                ack_seen = 1'b1;
                wait_cnt = wait_cnt + 1;
                if (wait_cnt == 2) begin
                    ack_valid = 1'b1;
                    dev_drv   = 1'b1;
                    wait_cnt  = 0;
                end
            end
        end
    end

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = s; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_all(input logic [15:0] f, input logic [15:0] c, input logic [15:0] i, input logic [15:0] s);
        load(2'd0, f); load(2'd1, c); load(2'd2, i); load(2'd3, s);
    endtask

    // Raises the chosen requests for one cycle, then counts busy cycles.
    task automatic fire(input logic n, input logic st, input logic m, input logic sw,
                        input logic r, output int cnt);
        @(negedge clk);
        nmi_req = n; step_req = st; mask_req = m; sw_req = sw; ret_req = r;
        @(negedge clk);
        nmi_req = 0; step_req = 0; mask_req = 0; sw_req = 0; ret_req = 0;
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        int c;
        logic [15:0] f0, c0, i0;
        logic [15:0] sp0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !int_ack && !mem_we && !mem_re, "R1 strobes", {12'h0, busy, int_ack, mem_we, mem_re}, 16'h0);
        check(flags_o == 0 && cs_o == 0 && ip_o == 0 && sp_o == 0, "R1 regs", flags_o | cs_o | ip_o | sp_o, 16'h0);
        rst_n = 1'b1;

        // R12: load port
        load_all(16'h0a5c, 16'h1234, 16'h5678, 16'h0900);
        check(flags_o == 16'h0a5c, "R12 flags", flags_o, 16'h0a5c);
        check(cs_o == 16'h1234, "R12 cs", cs_o, 16'h1234);
        check(ip_o == 16'h5678, "R12 ip", ip_o, 16'h5678);
        check(sp_o == 16'h0900, "R12 sp", sp_o, 16'h0900);

        // Sweep every software type through entry and return.
        for (int t = 0; t < 256; t++) begin
            f0  = 16'((t[0] ? 16'h0300 : 16'h0200) | (t & 16'h00f7));
            c0  = 16'(16'h2000 + t);
            i0  = 16'(16'h3000 + 2 * t);
            sp0 = t[1] ? 16'h0a00 : 16'h0800;
            load_all(f0, c0, i0, sp0);
            sw_type = 8'(t);
            fire(0, 0, 0, 1, 0, c);
            if (t == 0) check(c == 6, "R11 entry busy", 16'(c), 16'd6);
            check(ip_o == ip_of(t), "R4 ip", ip_o, ip_of(t));
            check(cs_o == cs_of(t), "R4 cs", cs_o, cs_of(t));
            check(flags_o == (f0 & 16'hfcff), "R3 flags", flags_o, f0 & 16'hfcff);
            check(sp_o == sp0 - 16'd6, "R2 sp", sp_o, sp0 - 16'd6);
            check(stk[10'((sp0 - 16'd2) >> 1)] == f0, "R2 R3 stacked flags", stk[10'((sp0 - 16'd2) >> 1)], f0);
            check(stk[10'((sp0 - 16'd4) >> 1)] == c0, "R2 stacked cs", stk[10'((sp0 - 16'd4) >> 1)], c0);
            check(stk[10'((sp0 - 16'd6) >> 1)] == i0, "R2 stacked ip", stk[10'((sp0 - 16'd6) >> 1)], i0);
            fire(0, 0, 0, 0, 1, c);
            if (t == 0) check(c == 4, "R11 return busy", 16'(c), 16'd4);
            check(ip_o == i0, "R5 ip", ip_o, i0);
            check(cs_o == c0, "R5 cs", cs_o, c0);
            check(flags_o == f0, "R5 flags", flags_o, f0);
            check(sp_o == sp0, "R5 sp", sp_o, sp0);
        end

        // R6: maskable request ignored with interrupts disabled
        load_all(16'h0000, 16'h1111, 16'h2222, 16'h0800);
        fire(0, 0, 1, 0, 0, c);
        check(c == 0, "R6 no busy", 16'(c), 16'd0);
        check(ip_o == 16'h2222 && sp_o == 16'h0800, "R6 regs kept", ip_o, 16'h2222);

        // R6 R10: maskable request with interrupts enabled
        load_all(16'h0200, 16'h1111, 16'h2222, 16'h0800);
        ack_seen = 1'b0;
        dev_type = 8'h21;
        fire(0, 0, 1, 0, 0, c);
        check(ack_seen, "R10 ack raised", 16'(ack_seen), 16'd1);
        check(ip_o == ip_of(8'h21), "R10 ip", ip_o, ip_of(8'h21));
        check(cs_o == cs_of(8'h21), "R10 cs", cs_o, cs_of(8'h21));
        check(c == 8, "R11 mask busy", 16'(c), 16'd8);

        // R7: non-maskable with both flags clear
        load_all(16'h0000, 16'h1111, 16'h2222, 16'h0800);
        fire(1, 0, 0, 0, 0, c);
        check(ip_o == ip_of(2), "R7 ip", ip_o, ip_of(2));
        check(cs_o == cs_of(2), "R7 cs", cs_o, cs_of(2));

        // R8: single-step ignored without trap flag, taken with it
        load_all(16'h0200, 16'h1111, 16'h2222, 16'h0800);
        fire(0, 1, 0, 0, 0, c);
        check(c == 0 && ip_o == 16'h2222, "R8 ignored", ip_o, 16'h2222);
        load(2'd0, 16'h0100);
        fire(0, 1, 0, 0, 0, c);
        check(ip_o == ip_of(1), "R8 ip", ip_o, ip_of(1));
        check(flags_o == 16'h0000, "R8 trap cleared", flags_o, 16'h0000);

        // R9: priorities with all lower sources pending
        sw_type = 8'h55;
        load_all(16'h0300, 16'h1111, 16'h2222, 16'h0800);
        fire(1, 1, 1, 1, 1, c);
        check(ip_o == ip_of(2), "R9 nmi first", ip_o, ip_of(2));
        load_all(16'h0300, 16'h1111, 16'h2222, 16'h0800);
        fire(0, 1, 1, 1, 1, c);
        check(ip_o == ip_of(1), "R9 step second", ip_o, ip_of(1));
        load_all(16'h0300, 16'h1111, 16'h2222, 16'h0800);
        fire(0, 0, 1, 1, 1, c);
        check(ip_o == ip_of(8'h21), "R9 mask third", ip_o, ip_of(8'h21));
        load_all(16'h0300, 16'h1111, 16'h2222, 16'h0800);
        fire(0, 0, 0, 1, 1, c);
        check(ip_o == ip_of(8'h55), "R9 sw before ret", ip_o, ip_of(8'h55));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=%h exp=%h", 16'h1, 16'h0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule